// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple single-word host request port to an asynchronous DRAM whose address pins are shared between row and column. The host presents a 16-bit word address, a direction flag and write data together with a one-clock request strobe. The controller splits the address into two 8-bit halves and sends them over the same eight pins. The low half goes out as the row and is latched when RAS falls. The high half goes out as the column and is latched when CAS falls. The controller then completes the transfer and signals the result with a one-clock done pulse.

The controller also keeps the memory alive. The stored charge lasts only one retention period, so a scheduler raises a refresh request every retention period divided by 256 clocks. Each request is served with a RAS-only cycle, and the rows are taken in turn from an internal 8-bit counter. A waiting refresh wins over a waiting host request, but a transfer that has already started always runs to its end. The host may post its next request at any time after its previous one has been taken up. A posted request waits in a one-deep holding register until the sequencer is free.

The cycle timing comes from parameters: the clock period and DRAM access time, which together set the CAS low time, the row hold time, the precharge time and the retention period in clocks.

Top module: `dram_addr_ctrl`

## Requirements
- R1: At the clock where RAS falls for a host access, the address pins carry host address bits [7:0] (the row). They hold that value for T_RAH clocks.
- R2: Host address bits [15:8] (the column) are on the address pins from the clock before CAS falls until CAS rises.
- R3: CAS falls exactly T_RAH+1 clocks after RAS falls. The address pins switch to the column T_RAH clocks after RAS falls, one clock before CAS.
- R4: CAS is low only while RAS is low, and only for host accesses. A refresh cycle never lowers CAS.
- R5: Between RAS rising and the next RAS fall, at least T_RP+1 clocks pass with RAS and CAS both high. After reset, RAS falls no earlier than T_RP+1 clocks after reset release.
- R6: For a write, WE is already low one clock before CAS falls and stays low until CAS rises. WE stays high for reads, for refresh and whenever RAS is high.
- R7: CAS stays low for exactly CAS_CYC = ceil(T_ACC_PS / CLK_PS) clocks. Read data is taken from the DRAM on the last of those clocks. done_o is high for exactly one clock, starting at the edge where CAS rises, and rdata_o is valid from that clock.
- R8: Refresh cycles are RAS-only cycles. Their row addresses run 0, 1, 2, … 255 and then wrap back to 0.
- R9: A refresh request is raised every RET_CYC/256 clocks. The refresh starts no later than one full access plus precharge after the request. If a refresh and a host request are both waiting when the sequencer becomes free, the refresh runs first and the host access follows. An access that has started is never cut short.
- R10: While rst_ni is low, RAS, CAS and WE are high, done_o is low and rdata_o is zero.
- R11: Data written to any address is read back unchanged at that same address. Writes to other addresses do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-clock request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with done_o |
| done_o | output | 1 | One-clock completion pulse |
| dram_addr_o | output | 8 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe and chip select, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | 8 | Data to DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 8 | Data from DRAM |

## Verification
A corrupted sequencer state or step counter shows up within one access at the strobe pins. The RAS-to-CAS spacing, the CAS width or the precharge gap then comes out wrong, and the model records the exact clock count. A wrong row or column half shows up when the behavioural memory stores the byte at a different address, even if a read-back through the same faulty path would hide it. A broken refresh counter or arbiter shows up within one refresh interval, as a skipped row, a widened gap, or a host access that overtakes a waiting refresh.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_REF,
    ST_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    MUX_ROW,
    MUX_COL,
    MUX_REF
  } mux_sel_e;
endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W   = 8,
  parameter int REF_INT = 976
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  logic             row_adv_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = $clog2(REF_INT + 1);

  logic [TW-1:0] tick_q;
  logic          tick;

  assign tick = (tick_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= TW'(REF_INT - 1);
    else if (tick) tick_q <= TW'(REF_INT - 1);
    else tick_q <= tick_q - 1'b1;
  end

  // a new tick wins over a grant in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else if (tick) pend_o <= 1'b1;
    else if (grant_i) pend_o <= 1'b0;
  end

  // row advances when its refresh completes, so the mux sees the current row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_o <= '0;
    else if (row_adv_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int T_RAH   = 1,
  parameter int CAS_CYC = 9,
  parameter int T_RP    = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ref_pend_i,
  input  logic     host_pend_i,
  input  logic     host_wr_i,
  output logic     ref_grant_o,
  output logic     host_grant_o,
  output logic     row_adv_o,
  output logic     xfer_end_o,
  output logic     is_wr_o,
  output logic     ras_n_o,
  output logic     cas_n_o,
  output logic     we_n_o,
  output logic     dq_oe_o,
  output mux_sel_e mux_sel_o
);
  localparam int REF_RAS = T_RAH + 1 + CAS_CYC;
  localparam int MAXC    = (REF_RAS > T_RP) ? REF_RAS : T_RP;
  localparam int CW      = $clog2(MAXC + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    wr_d         = wr_q;
    ref_grant_o  = 1'b0;
    host_grant_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_i) begin
          state_d     = ST_REF;
          cnt_d       = CW'(REF_RAS - 1);
          ref_grant_o = 1'b1;
        end else if (host_pend_i) begin
          state_d      = ST_ROW;
          cnt_d        = CW'(T_RAH - 1);
          wr_d         = host_wr_i;
          host_grant_o = 1'b1;
        end
      end
      ST_ROW: begin
        if (cnt_q == '0) state_d = ST_COL;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_COL: begin
        state_d = ST_CAS;
        cnt_d   = CW'(CAS_CYC - 1);
      end
      ST_CAS, ST_REF: begin
        if (cnt_q == '0) begin
          state_d = ST_PRE;
          cnt_d   = CW'(T_RP - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_PRE: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_PRE;
    endcase
  end

  // reset lands in precharge so the first RAS also honours T_RP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PRE;
      cnt_q   <= CW'(T_RP - 1);
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  logic in_col_phase;
  assign in_col_phase = (state_q == ST_COL) || (state_q == ST_CAS);

  assign ras_n_o    = !((state_q == ST_ROW) || in_col_phase || (state_q == ST_REF));
  assign cas_n_o    = !(state_q == ST_CAS);
  assign we_n_o     = !(wr_q && in_col_phase);
  assign dq_oe_o    = wr_q && in_col_phase;
  assign xfer_end_o = (state_q == ST_CAS) && (cnt_q == '0);
  assign row_adv_o  = (state_q == ST_REF) && (cnt_q == '0);
  assign is_wr_o    = wr_q;

  always_comb begin
    if (state_q == ST_REF) mux_sel_o = MUX_REF;
    else if (in_col_phase) mux_sel_o = MUX_COL;
    else mux_sel_o = MUX_ROW;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int MUX_W = 8
) (
  input  mux_sel_e           sel_i,
  input  logic [2*MUX_W-1:0] host_addr_i,
  input  logic [MUX_W-1:0]   ref_row_i,
  output logic [MUX_W-1:0]   mux_o
);
  // low half is the row, high half the column
  always_comb begin
    unique case (sel_i)
      MUX_COL: mux_o = host_addr_i[2*MUX_W-1:MUX_W];
      MUX_REF: mux_o = ref_row_i;
      default: mux_o = host_addr_i[MUX_W-1:0];
    endcase
  end
endmodule

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 8000,
  parameter int T_ACC_PS = 70000,
  parameter int RET_CYC  = 250000,
  parameter int T_RAH    = 1,
  parameter int T_RP     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W/2-1:0] dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int MUX_W    = ADDR_W / 2;
  localparam int NUM_ROWS = 1 << MUX_W;
  localparam int REF_INT  = RET_CYC / NUM_ROWS;
  localparam int CAS_CYC  = (T_ACC_PS + CLK_PS - 1) / CLK_PS;

  logic              pend_q, pw_q;
  logic [ADDR_W-1:0] pa_q, cur_a_q;
  logic [DATA_W-1:0] pd_q, cur_d_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic             ref_pend, ref_grant, host_grant, row_adv, xfer_end, is_wr;
  logic [MUX_W-1:0] ref_row;
  mux_sel_e         mux_sel;

  // one-deep holding slot; refilling in the grant cycle is allowed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pw_q    <= 1'b0;
      pa_q    <= '0;
      pd_q    <= '0;
      cur_a_q <= '0;
      cur_d_q <= '0;
    end else begin
      if (host_grant) begin
        cur_a_q <= pa_q;
        cur_d_q <= pd_q;
      end
      if (req_i && (!pend_q || host_grant)) begin
        pend_q <= 1'b1;
        pw_q   <= wr_i;
        pa_q   <= addr_i;
        pd_q   <= wdata_i;
      end else if (host_grant) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= xfer_end;
      if (xfer_end && !is_wr) rdata_q <= dram_dq_i;
    end
  end

  dram_refresh_sched #(
    .ROW_W  (MUX_W),
    .REF_INT(REF_INT)
  ) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .grant_i  (ref_grant),
    .row_adv_i(row_adv),
    .pend_o   (ref_pend),
    .row_o    (ref_row)
  );

  dram_seq_fsm #(
    .T_RAH  (T_RAH),
    .CAS_CYC(CAS_CYC),
    .T_RP   (T_RP)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_pend_i  (ref_pend),
    .host_pend_i (pend_q),
    .host_wr_i   (pw_q),
    .ref_grant_o (ref_grant),
    .host_grant_o(host_grant),
    .row_adv_o   (row_adv),
    .xfer_end_o  (xfer_end),
    .is_wr_o     (is_wr),
    .ras_n_o     (dram_ras_no),
    .cas_n_o     (dram_cas_no),
    .we_n_o      (dram_we_no),
    .dq_oe_o     (dram_dq_oe_o),
    .mux_sel_o   (mux_sel)
  );

  dram_addr_mux #(
    .MUX_W(MUX_W)
  ) u_mux (
    .sel_i      (mux_sel),
    .host_addr_i(cur_a_q),
    .ref_row_i  (ref_row),
    .mux_o      (dram_addr_o)
  );

  assign dram_dq_o = cur_d_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/dram_addr_ctrl_chk.sv
module dram_addr_ctrl_chk #(
  parameter int CLK_PS   = 8000,
  parameter int T_ACC_PS = 70000,
  parameter int T_RP     = 2,
  parameter int MUX_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n_i,
  input logic             cas_n_i,
  input logic             we_n_i,
  input logic             done_i,
  input logic [MUX_W-1:0] addr_i
);
  localparam int CAS_CYC = (T_ACC_PS + CLK_PS - 1) / CLK_PS;

  logic [7:0]  hi_q;
  logic [15:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (ras_n_i) hi_q <= (hi_q == 8'hFF) ? hi_q : hi_q + 8'd1;
      else hi_q <= '0;
      if (!cas_n_i) lo_q <= (lo_q == 16'hFFFF) ? lo_q : lo_q + 16'd1;
      else lo_q <= '0;
    end
  end

  p_cas_in_ras_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_i |-> !ras_n_i);

  p_precharge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_i) |-> (int'(hi_q) >= T_RP + 1));

  p_col_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_i) |-> $stable(addr_i));

  p_col_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_i && !$fell(cas_n_i)) |-> $stable(addr_i));

  p_we_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_i) |-> $stable(we_n_i));

  p_we_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_i && !we_n_i) |=> (!we_n_i || cas_n_i));

  p_we_in_ras_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> !ras_n_i);

  p_cas_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_i) |-> (int'(lo_q) == CAS_CYC));

  p_done_at_cas_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_i) |-> done_i);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind dram_addr_ctrl dram_addr_ctrl_chk #(
  .CLK_PS  (CLK_PS),
  .T_ACC_PS(T_ACC_PS),
  .T_RP    (T_RP),
  .MUX_W   (ADDR_W / 2)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ras_n_i(dram_ras_no),
  .cas_n_i(dram_cas_no),
  .we_n_i (dram_we_no),
  .done_i (done_o),
  .addr_i (dram_addr_o)
);

// File: tb/dram_addr_ctrl_tb.sv
module dram_addr_ctrl_tb;
  localparam int CLK_PS   = 8000;
  localparam int T_ACC_PS = 70000;
  localparam int T_RAH    = 1;
  localparam int T_RP     = 2;
  localparam int RET_CYC  = 10240;
  localparam int REF_INT  = RET_CYC / 256;
  localparam int CAS_CYC  = (T_ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int ACC_MAX  = T_RAH + CAS_CYC + T_RP + 3;

  // {wr, addr, data}; for reads data is the expected value
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h0000, 8'hA5}, {1'b1, 16'h12AB, 8'h3C}, {1'b1, 16'hFFFF, 8'h81},
    {1'b1, 16'h00FF, 8'h5E}, {1'b1, 16'hFF00, 8'hE7}, {1'b0, 16'h12AB, 8'h3C},
    {1'b0, 16'h0000, 8'hA5}, {1'b0, 16'hFF00, 8'hE7}, {1'b0, 16'h00FF, 8'h5E},
    {1'b0, 16'hFFFF, 8'h81}, {1'b1, 16'h12AB, 8'hC4}, {1'b0, 16'h12AB, 8'hC4},
    {1'b0, 16'hAB12, 8'hE3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, dq_o, dq_i, rd_q;
  logic        done, ras_n, cas_n, we_n, dq_oe;
  logic [7:0]  maddr;

  always #4 clk = ~clk;

  dram_addr_ctrl #(
    .CLK_PS(CLK_PS), .T_ACC_PS(T_ACC_PS), .RET_CYC(RET_CYC), .T_RAH(T_RAH), .T_RP(T_RP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_o(done), .dram_addr_o(maddr), .dram_ras_no(ras_n),
    .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe),
    .dram_dq_i(dq_i)
  );

  // behavioural memory and protocol monitor, sampled at negedges
  logic [7:0] mem [int];
  int ecyc = 0;
  int fall_ras = 0, rise_ras = 0, fall_cas = 0, rise_cas = 0;
  int we_lo = 0, we_hi = 0, we_fall = 1;
  int pre_bad = 0, r4_bad = 0, we_out_bad = 0, ref_bad = 0, gap_bad = 0;
  int ref_cnt = 0, acc_cnt = 0, exp_ref_row = 0, last_ref_fall = 0;
  int acc_row = 0, acc_col = 0;
  logic [7:0] row_l = '0, col_l = '0;
  logic       cas_seen = 1'b0, prev_ras = 1'b1, prev_cas = 1'b1;
  logic [2:0] hist = '0;
  logic       oe_bad = 1'b0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign dq_i = (!cas_n && we_n) ? rd_q : 8'h00;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecyc <= 0;
    else ecyc <= ecyc + 1;

  initial rd_q = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        fall_ras = ecyc;
        if (ecyc - rise_ras < T_RP + 1) pre_bad++;
        cas_seen = 1'b0;
        row_l = maddr;
        we_lo = 0;
        we_hi = 0;
      end
      if (prev_cas && !cas_n) begin
        fall_cas = ecyc;
        col_l = maddr;
        cas_seen = 1'b1;
        we_fall = int'(we_n);
        if (!we_n) mem[int'({col_l, row_l})] = dq_o;
        rd_q = mem.exists(int'({col_l, row_l})) ? mem[int'({col_l, row_l})] : pat({col_l, row_l});
      end
      if (!cas_n) begin
        if (we_n) we_hi++;
        else we_lo++;
        if (maddr != col_l) r4_bad++;
        if (!we_n && !dq_oe) oe_bad = 1'b1;
      end
      if (!cas_n && ras_n) r4_bad++;
      if (!we_n && ras_n) we_out_bad++;
      if (!prev_cas && cas_n) rise_cas = ecyc;
      if (!prev_ras && ras_n) begin
        rise_ras = ecyc;
        hist = {hist[1:0], !cas_seen};
        if (!cas_seen) begin
          if (int'(row_l) != exp_ref_row) ref_bad++;
          exp_ref_row = (exp_ref_row + 1) % 256;
          if (ref_cnt > 0) begin
            if (fall_ras - last_ref_fall > REF_INT + ACC_MAX) gap_bad++;
            if (fall_ras - last_ref_fall < REF_INT - ACC_MAX) gap_bad++;
          end
          last_ref_fall = fall_ras;
          ref_cnt++;
        end else begin
          acc_cnt++;
          acc_row = int'(row_l);
          acc_col = int'(col_l);
        end
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  int n_pass = 0, n_tot = 0;
  bit finished = 1'b0;
  int host_acc = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  endtask

  task automatic wait_done(output logic [7:0] rd, output int dcyc);
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R7 done seen", int'(done), 1);
    rd = rdata;
    dcyc = ecyc;
    @(negedge clk);
    chk(done === 1'b0, "R7 done one clock", int'(done), 0);
  endtask

  task automatic do_acc(input logic w, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    int dcyc;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    host_acc++;
    wait_done(rd, dcyc);
    chk(acc_row == int'(a[7:0]), "R1 row half", acc_row, int'(a[7:0]));
    chk(acc_col == int'(a[15:8]), "R2 column half", acc_col, int'(a[15:8]));
    chk(fall_cas - fall_ras == T_RAH + 1, "R3 RAS to CAS", fall_cas - fall_ras, T_RAH + 1);
    chk(rise_cas - fall_cas == CAS_CYC, "R7 CAS width", rise_cas - fall_cas, CAS_CYC);
    chk(rise_cas == dcyc, "R7 done with CAS rise", dcyc, rise_cas);
    if (w) begin
      chk(we_hi == 0 && we_fall == 0, "R6 WE low over CAS", we_hi, 0);
      chk(mem.exists(int'(a)) && mem[int'(a)] == d, "R11 stored at address",
          mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, int'(d));
    end else begin
      chk(we_lo == 0, "R6 WE high on read", we_lo, 0);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      n_tot++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    int dcyc, n;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R10 strobes idle",
        int'({ras_n, cas_n, we_n}), 7);
    chk(done === 1'b0 && rdata === 8'h00, "R10 outputs cleared", int'(rdata), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_acc(VEC[i][24], VEC[i][23:8], VEC[i][7:0], rd);
      if (!VEC[i][24]) chk(rd == VEC[i][7:0], "R11 read data", int'(rd), int'(VEC[i][7:0]));
    end

    // R9 priority: refresh tick lands during access A while B waits
    while (ecyc % REF_INT != REF_INT - 6) @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 16'hBEEF; wdata = 8'h77;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = 16'hBEEF;
    @(negedge clk);
    req = 1'b0;
    host_acc += 2;
    wait_done(rd, dcyc);
    wait_done(rd, dcyc);
    chk(rd == 8'h77, "R11 read after queued write", int'(rd), 8'h77);
    chk(hist == 3'b010, "R9 refresh before waiting host", int'(hist), 2);

    // run until the refresh row counter wraps
    n = 0;
    while (ref_cnt < 260 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(ref_cnt >= 260, "R8 refresh count", ref_cnt, 260);
    chk(ref_bad == 0, "R8 refresh row order", ref_bad, 0);
    chk(gap_bad == 0, "R9 refresh spacing", gap_bad, 0);
    chk(pre_bad == 0, "R5 precharge gap", pre_bad, 0);
    chk(r4_bad == 0, "R4 CAS inside RAS", r4_bad, 0);
    chk(acc_cnt == host_acc, "R4 CAS only for host", acc_cnt, host_acc);
    chk(we_out_bad == 0 && !oe_bad, "R6 WE outside RAS", we_out_bad, 0);
    finish_run();
  end
endmodule